// File: doc/BRIEF.md
# Three-operand ripple adder with a share chain

This block adds three unsigned N-bit operands and a carry-in. It does this on one ripple carry chain, not on a tree of two-operand adders. The datapath is a row of bit slices. Each slice evaluates two 4-input lookup functions on the same operand bits. One function feeds the slice's own full adder. The other function is passed sideways on a share chain into the adder of the next bit up. With the default tables, the sideways function is the majority of the three bits and the local function is their XOR. The slices therefore form a carry-save compressor whose second row is absorbed by the carry chain. Two slices make one cell, so each cell adds three bits rather than two.

A mode parameter selects plain arithmetic instead. In that mode the second function is inverted and added locally, and the share input is ignored. The block is purely combinational. N must be even so that slices pair into cells.

Top module: `tri_add_chain`

## Requirements
- R1: In shared mode with the default tables, `total` equals `op_a + op_b + op_c + carry_in` exactly, over N+2 bits. The local table is 16'h9696 (XOR) and the share table is 16'hE8E8 (majority). Both are indexed by {0, c, b, a}, with a as the least significant bit.
- R2: In shared mode the extremes do not wrap. All-zero operands with `carry_in`=0 give 0. All-ones operands with `carry_in`=1 give 3·(2^N−1)+1.
- R3: In arithmetic mode each bit adds its local function, the inverse of its share function and the incoming carry. With local table 16'hAAAA (value a) and share table 16'h3333 (inverse of b), `total` equals `op_a + op_b + carry_in`.
- R4: In arithmetic mode `total[N+1]` is always 0 and `total[N]` is the carry out of the top bit.
- R5: Raising `carry_in` from 0 to 1 with the operands unchanged raises `total` by exactly one.
- R6: The result has no clock and no state. It depends only on the present inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | N | first operand |
| op_b | input | N | second operand |
| op_c | input | N | third operand (ignored by the arithmetic-mode tables used in the tests) |
| carry_in | input | 1 | carry into bit 0 |
| total | output | N+2 | sum; in shared mode the top two bits combine final carry and final share |

## Verification
Every result is due zero cycles after its stimulus, because the block holds no register. The driver applies operands just after a rising edge and queues the expected sum. The monitor pops and compares that sum on the following falling edge, once the chain has settled. Shared mode is swept over every operand and carry-in combination at N=4 and with random operands at N=16. Arithmetic mode is swept over every combination at N=4, and paired carry-in stimuli isolate the effect of the carry alone.

// File: rtl/tac_pkg.sv
// Package: shared types and helpers for the three-operand adder chain.
// Assumes 16-entry lookup tables indexed by a 4-bit select.
package tac_pkg;
    typedef enum logic {
        TAC_ARITH  = 1'b0,
        TAC_SHARED = 1'b1
    } tac_mode_e;

    localparam int LUT_BITS = 16;

    // Reads one entry of a 16-entry table.
    function automatic logic lut_pick(input logic [LUT_BITS-1:0] tbl,
                                      input logic [3:0] sel);
        return tbl[sel];
    endfunction
endpackage

// File: rtl/tac_slice.sv
// Module: tac_slice - one bit position of the chain.
// Two 4-input functions read {0, z, y, x}. In shared mode the adder takes the
// neighbour's share input. In arithmetic mode it takes the inverted share function.
// Assumes the fourth function input is tied low.
module tac_slice #(
    parameter logic [15:0]       ADD_TBL = 16'h9696,
    parameter logic [15:0]       SHR_TBL = 16'hE8E8,
    parameter tac_pkg::tac_mode_e MODE   = tac_pkg::TAC_SHARED
) (
    input  logic x,
    input  logic y,
    input  logic z,
    input  logic share_in,
    input  logic carry_in,
    output logic sum_bit,
    output logic carry_out,
    output logic share_out
);
    logic [3:0] sel;
    logic       add_fn;
    logic       shr_fn;
    logic       opnd;

    // Evaluate both lookup functions and the full adder bit.
    always_comb begin
        sel    = {1'b0, z, y, x};
        add_fn = tac_pkg::lut_pick(ADD_TBL, sel);
        shr_fn = tac_pkg::lut_pick(SHR_TBL, sel);
        opnd   = (MODE == tac_pkg::TAC_SHARED) ? share_in : ~shr_fn;
        {carry_out, sum_bit} = 2'(add_fn) + 2'(opnd) + 2'(carry_in);
        share_out = shr_fn;
    end
endmodule

// File: rtl/tac_cell.sv
// Module: tac_cell - a pair of slices.
// The carry ripples from the lower slice to the upper one. The lower share
// output feeds the upper adder, and the upper share function leaves the cell.
module tac_cell #(
    parameter logic [1:0][15:0]  ADD_TBL = {2{16'h9696}},
    parameter logic [1:0][15:0]  SHR_TBL = {2{16'hE8E8}},
    parameter tac_pkg::tac_mode_e MODE   = tac_pkg::TAC_SHARED
) (
    input  logic [1:0] x,
    input  logic [1:0] y,
    input  logic [1:0] z,
    input  logic       share_in,
    input  logic       carry_in,
    output logic [1:0] sum_bits,
    output logic       carry_out,
    output logic       share_out
);
    logic [2:0] carry;
    logic [2:0] share;

    assign carry[0]  = carry_in;
    assign share[0]  = share_in;
    assign carry_out = carry[2];
    assign share_out = share[2];

    for (genvar s = 0; s < 2; s++) begin : g_half
        tac_slice #(
            .ADD_TBL(ADD_TBL[s]),
            .SHR_TBL(SHR_TBL[s]),
            .MODE   (MODE)
        ) u_slice (
            .x        (x[s]),
            .y        (y[s]),
            .z        (z[s]),
            .share_in (share[s]),
            .carry_in (carry[s]),
            .sum_bit  (sum_bits[s]),
            .carry_out(carry[s+1]),
            .share_out(share[s+1])
        );
    end
endmodule

// File: rtl/tri_add_chain.sv
// Module: tri_add_chain - three-operand adder on one carry chain.
// Builds N/2 cells. The share input of bit 0 is zero. In shared mode the top
// two result bits are the final carry plus the final share. In arithmetic
// mode they are {0, carry}. Assumes N is even.
module tri_add_chain #(
    parameter int                  N       = 4,
    parameter logic [N-1:0][15:0]  ADD_TBL = {N{16'h9696}},
    parameter logic [N-1:0][15:0]  SHR_TBL = {N{16'hE8E8}},
    parameter tac_pkg::tac_mode_e  MODE    = tac_pkg::TAC_SHARED
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic [N-1:0] op_c,
    input  logic         carry_in,
    output logic [N+1:0] total
);
    localparam int CELLS = N / 2;

    if ((N % 2) != 0 || N < 2) begin : g_bad_width
        $error("tri_add_chain: N must be even and at least 2");
    end

    logic [CELLS:0] carry;
    logic [CELLS:0] share;
    logic [N-1:0]   low_bits;

    assign carry[0] = carry_in;
    assign share[0] = 1'b0;

    for (genvar k = 0; k < CELLS; k++) begin : g_cell
        tac_cell #(
            .ADD_TBL(ADD_TBL[2*k +: 2]),
            .SHR_TBL(SHR_TBL[2*k +: 2]),
            .MODE   (MODE)
        ) u_cell (
            .x        (op_a[2*k +: 2]),
            .y        (op_b[2*k +: 2]),
            .z        (op_c[2*k +: 2]),
            .share_in (share[k]),
            .carry_in (carry[k]),
            .sum_bits (low_bits[2*k +: 2]),
            .carry_out(carry[k+1]),
            .share_out(share[k+1])
        );
    end

    // Merge the chain ends into the two top result bits.
    always_comb begin
        total[N-1:0] = low_bits;
        if (MODE == tac_pkg::TAC_SHARED)
            total[N+1:N] = 2'(carry[CELLS]) + 2'(share[CELLS]);
        else
            total[N+1:N] = {1'b0, carry[CELLS]};
    end
endmodule

// File: rtl/tri_add_chain_chk.sv
// Module: tri_add_chain_chk - assertion checker bound to tri_add_chain.
// Checks apply only to the table sets whose meaning is fixed by the requirements.
module tri_add_chain_chk #(
    parameter int                  N       = 4,
    parameter logic [N-1:0][15:0]  ADD_TBL = {N{16'h9696}},
    parameter logic [N-1:0][15:0]  SHR_TBL = {N{16'hE8E8}},
    parameter tac_pkg::tac_mode_e  MODE    = tac_pkg::TAC_SHARED
) (
    input logic [N-1:0] op_a,
    input logic [N-1:0] op_b,
    input logic [N-1:0] op_c,
    input logic         carry_in,
    input logic [N+1:0] total
);
    localparam bit SH_DEF = (MODE == tac_pkg::TAC_SHARED) &&
                            (ADD_TBL == {N{16'h9696}}) && (SHR_TBL == {N{16'hE8E8}});
    localparam bit AR_DEF = (MODE == tac_pkg::TAC_ARITH) &&
                            (ADD_TBL == {N{16'hAAAA}}) && (SHR_TBL == {N{16'h3333}});
    localparam logic [N+1:0] MAX_SUM = (N+2)'(3) * (N+2)'({N{1'b1}}) + (N+2)'(1);

    logic [N+1:0] want3;
    logic [N+1:0] want2;

    // Check the result against the arithmetic it must equal.
    always_comb begin
        want3 = (N+2)'(op_a) + (N+2)'(op_b) + (N+2)'(op_c) + (N+2)'(carry_in);
        want2 = (N+2)'(op_a) + (N+2)'(op_b) + (N+2)'(carry_in);
        // R1
        sum3_exact_chk: assert (!SH_DEF || total == want3);
        // R2
        no_overflow_chk: assert (!SH_DEF || total <= MAX_SUM);
        // R3
        sum2_exact_chk: assert (!AR_DEF || total == want2);
        // R4
        arith_top_zero_chk: assert (MODE != tac_pkg::TAC_ARITH || total[N+1] == 1'b0);
    end
endmodule

bind tri_add_chain tri_add_chain_chk #(
    .N(N), .ADD_TBL(ADD_TBL), .SHR_TBL(SHR_TBL), .MODE(MODE)
) u_chk (
    .op_a(op_a), .op_b(op_b), .op_c(op_c), .carry_in(carry_in), .total(total)
);

// File: tb/sim_tri_add_chain.sv
// Bench: scoreboard test of three chain configurations.
module sim_tri_add_chain;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [3:0]  a0, b0, c0;  logic ci0; logic [5:0]  t0;
    logic [15:0] a1, b1, c1;  logic ci1; logic [17:0] t1;
    logic [3:0]  a2, b2, c2;  logic ci2; logic [5:0]  t2;

    tri_add_chain #(.N(4)) u0 (.op_a(a0), .op_b(b0), .op_c(c0), .carry_in(ci0), .total(t0));
    tri_add_chain #(.N(16)) u1 (.op_a(a1), .op_b(b1), .op_c(c1), .carry_in(ci1), .total(t1));
    tri_add_chain #(.N(4), .ADD_TBL({4{16'hAAAA}}), .SHR_TBL({4{16'h3333}}),
                    .MODE(tac_pkg::TAC_ARITH))
        u2 (.op_a(a2), .op_b(b2), .op_c(c2), .carry_in(ci2), .total(t2));

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Apply one stimulus after a rising edge and queue its expected result.
    task automatic drive(input int sel, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c, input logic ci, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        case (sel)
            0: begin a0 = a[3:0];  b0 = b[3:0];  c0 = c[3:0];  ci0 = ci; end
            1: begin a1 = a[15:0]; b1 = b[15:0]; c1 = c[15:0]; ci1 = ci; end
            default: begin a2 = a[3:0]; b2 = b[3:0]; c2 = c[3:0]; ci2 = ci; end
        endcase
        it.sel = sel;
        it.tag = tag;
        if (sel == 2) it.exp = a + b + 32'(ci);
        else          it.exp = a + b + c + 32'(ci);
        sb.push_back(it);
    endtask

    // Pop and compare on the falling edge; results are combinational (R6).
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it = sb.pop_front();
            case (it.sel)
                0: got = 32'(t0);
                1: got = 32'(t1);
                default: got = 32'(t2);
            endcase
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s sel=%0d got=%0h exp=%0h", it.tag, it.sel, got, it.exp);
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        {a0, b0, c0, ci0} = '0;
        {a1, b1, c1, ci1} = '0;
        {a2, b2, c2, ci2} = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: all-zero inputs give zero (R2, R6).
        drive(0, 0, 0, 0, 1'b0, "R2");
        drive(1, 0, 0, 0, 1'b0, "R2");
        // Extremes do not wrap (R2).
        drive(0, 32'hF, 32'hF, 32'hF, 1'b1, "R2");
        drive(1, 32'hFFFF, 32'hFFFF, 32'hFFFF, 1'b1, "R2");
        // Carry-in adds exactly one (R5).
        drive(1, 32'h1234, 32'hABCD, 32'h0F0F, 1'b0, "R5");
        drive(1, 32'h1234, 32'hABCD, 32'h0F0F, 1'b1, "R5");
        drive(2, 32'h7, 32'h9, 0, 1'b0, "R5");
        drive(2, 32'h7, 32'h9, 0, 1'b1, "R5");
        // Exhaustive shared mode at N=4 (R1).
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int c = 0; c < 16; c++)
                    for (int ci = 0; ci < 2; ci++)
                        drive(0, 32'(a), 32'(b), 32'(c), ci[0], "R1");
        // Random shared mode at N=16 (R1).
        for (int n = 0; n < 3000; n++)
            drive(1, {16'h0, $urandom()} & 32'hFFFF, $urandom() & 32'hFFFF,
                  $urandom() & 32'hFFFF, $urandom() & 1, "R1");
        // Exhaustive arithmetic mode; op_c varies and must not matter (R3, R4).
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int ci = 0; ci < 2; ci++)
                    drive(2, 32'(a), 32'(b), 32'((a * 5 + b) & 15), ci[0],
                          (a + b + ci > 15) ? "R4" : "R3");
        repeat (4) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule